// File: doc/BRIEF.md
# ADC Startup Register Sequencer

This block brings a high-speed data converter's digital output interface into a working state without software. It leaves reset and starts on its own. It can also be restarted with a one-cycle start pulse. It then emits an ordered list of register writes, as 8-bit address and 8-bit data pairs, to a downstream serial-bus master over a valid/ready handshake. The list and the values in it follow from these inputs:

- the lane mode (2-wire, 1-wire or half-wire);
- the output resolution;
- whether complex decimation is used;
- whether the scrambler is wanted;
- the NCO frequency word;
- the decimation gain.

The converter's fuse loader rewrites part of the register file, so the lane-mode write and the fuse-load pulse always come first. The fuse-load pulse is a set write, a wait of about one millisecond timed by a down-counter, and a clear write. The frame-clock setup, the IQ alignment bits, the optional data-path enables and the NCO frequency bytes follow. The list ends with the gain write and an NCO reset toggle that makes the new frequency take effect.

All configuration inputs are captured at the moment the sequence launches. A sequence in progress is never disturbed by input changes or further start pulses. The `busy` and `done` outputs report progress. The `cfg_err` output reports a scrambler request the lane mode cannot honour, or a reserved lane code.

Top module: `adc_init_sequencer`

## Requirements
- R1: While `rst` is high, `wr_valid` and `done` are 0 and `busy` is 1. On the first clock after `rst` falls, the configuration inputs are captured and a sequence begins without any start pulse.
- R2: A sequence contains these writes, in this order. Bracketed writes are conditional (R7, R9).
  - 0x07
  - 0x13←0x01
  - 0x13←0x00
  - 0x19
  - 0x20, 0x21, 0x22
  - 0x27, 0x2E
  - [0x24]
  - [0x2A..0x2D, 0x31..0x34]
  - 0x26, 0x26

  The clear write 0x13←0x00 is not offered until at least CLK_HZ/1000 cycles after the set write is accepted.
- R3: The value written to 0x07 depends on the lane code `lane_mode` (0 = 2-wire, 1 = 1-wire, 2 = half-wire) and the resolution code `out_res` (0/1/2/3 = 14/16/18/20 bits).
  - 2-wire: 0x2B for codes 0 and 2, 0x4B for codes 1 and 3.
  - 1-wire: 0x6C.
  - Half-wire: 0x8D.
- R4: 0x19 carries the frame-clock source in bit 0, divide in bit 1 and toggle in bit 2.
  - Without complex decimation: 0x02 in 2-wire mode, 0x00 otherwise.
  - With complex decimation: 0x01 in 2-wire and 1-wire modes, 0x04 in half-wire mode.
- R5: A 20-bit frame pattern is written most-significant first: 0x20 receives bits 19:16 in its low nibble, 0x21 bits 15:8, 0x22 bits 7:0.
  - With complex decimation the pattern is 0xFFFFF.
  - Otherwise, 2-wire mode uses 0xFFC00 / 0xFF000 / 0xFF800 / 0xFFC00 for resolution codes 0 / 1 / 2 / 3.
  - Otherwise, 1-wire mode uses 0xFE000 and half-wire mode uses 0xFFC00.
- R6: Bit 0 of 0x27 (IQ order) and bit 0 of 0x2E (Q delay) are both 0 without complex decimation. With it, (order, delay) is (1,0) in 2-wire, (0,1) in 1-wire and (1,1) in half-wire; all other bits are 0.
- R7: 0x24 is written only when the scrambler is granted (`scramble_req` with 2-wire mode) or complex decimation is on. Bit 0 is the scrambler enable, bit 1 the decimation enable, other bits 0.
- R8: A scrambler request in a lane mode other than 2-wire leaves the scrambler bit at 0 and raises `cfg_err`. Lane code 3 is reserved: it is sequenced as half-wire and raises `cfg_err`. `cfg_err` is fixed at launch and holds until the next launch.
- R9: With complex decimation, NCO bytes 0..3 (least significant first) of `nco_freq` go to 0x2A..0x2D and bytes 4..7 go to 0x31..0x34. Without it, none of these addresses is written.
- R10: The sequence ends with two writes to 0x26, both carrying `ddc_gain` in bits GAIN_W:1. The first has bit 0 (NCO reset) set, the second has it clear.
- R11: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values to the next cycle.
- R12: A start pulse while `busy` is ignored. Input changes after launch do not alter the sequence. `done` rises after the last write is accepted and stays high until a start pulse, which launches a new sequence with freshly captured inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, honoured only when not busy |
| lane_mode | input | 2 | Lane code: 0 2-wire, 1 1-wire, 2 half-wire, 3 reserved |
| out_res | input | 2 | Resolution code: 0/1/2/3 = 14/16/18/20 bits |
| cplx_dec_en | input | 1 | Complex decimation enable |
| scramble_req | input | 1 | Scrambler request |
| nco_freq | input | 64 | NCO frequency word |
| ddc_gain | input | GAIN_W | Decimation gain code |
| wr_valid | output | 1 | Write request offered |
| wr_ready | input | 1 | Downstream master accepts the write |
| wr_addr | output | 8 | Register address |
| wr_data | output | 8 | Register data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished |
| cfg_err | output | 1 | Unsupported request seen at launch |

## Verification
The sequence is checked against a bench-computed list of writes. Every lane code is crossed with every resolution code with complex decimation off, which separates the resolution-dependent 2-wire values from the fixed 1-wire and half-wire ones. Each lane code is then run with complex decimation on, which exposes the frame-clock, pattern, IQ and NCO differences. Scrambler requests appear in every lane mode, to tell a granted scrambler apart from a refused one that must raise `cfg_err`. Random configurations with random `wr_ready` stalls, a launch from reset, a start pulse injected mid-sequence and inputs scrambled after launch cover holding under back-pressure and input capture.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 8;
    localparam int NCO_W     = 64;
    localparam int NCO_BYTES = NCO_W / 8;
    localparam int PAT_W     = 20;
    localparam int GAIN_FW   = 7;
    localparam int NSTEPS    = 21;
    localparam int STEP_W    = $clog2(NSTEPS);
    localparam int NCO_FIRST = 11;

    localparam logic [ADDR_W-1:0] A_IFMODE  = 8'h07;
    localparam logic [ADDR_W-1:0] A_FUSE    = 8'h13;
    localparam logic [ADDR_W-1:0] A_FCLK    = 8'h19;
    localparam logic [ADDR_W-1:0] A_PAT_HI  = 8'h20;
    localparam logic [ADDR_W-1:0] A_PAT_MID = 8'h21;
    localparam logic [ADDR_W-1:0] A_PAT_LO  = 8'h22;
    localparam logic [ADDR_W-1:0] A_DPEN    = 8'h24;
    localparam logic [ADDR_W-1:0] A_GAIN    = 8'h26;
    localparam logic [ADDR_W-1:0] A_IQORD   = 8'h27;
    localparam logic [ADDR_W-1:0] A_NCO_LO  = 8'h2A;
    localparam logic [ADDR_W-1:0] A_QDEL    = 8'h2E;
    localparam logic [ADDR_W-1:0] A_NCO_HI  = 8'h31;

    typedef enum logic [1:0] {
        LANE_2W   = 2'd0,
        LANE_1W   = 2'd1,
        LANE_HALF = 2'd2,
        LANE_RSVD = 2'd3
    } lane_e;

    typedef enum logic [1:0] {
        RES_14 = 2'd0,
        RES_16 = 2'd1,
        RES_18 = 2'd2,
        RES_20 = 2'd3
    } res_e;

    typedef enum logic [1:0] {
        ST_LAUNCH = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_WAIT   = 2'd2,
        ST_DONE   = 2'd3
    } seq_state_e;

    typedef struct packed {
        lane_e              lane;
        res_e               res;
        logic               cplx;
        logic               scr_on;
        logic [NCO_W-1:0]   nco;
        logic [GAIN_FW-1:0] gain;
    } seq_cfg_t;

    typedef struct packed {
        logic              used;
        logic              is_wait;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } step_t;

    // Reserved lane code is sequenced as half-wire.
    function automatic lane_e eff_lane(input lane_e l);
        return (l == LANE_RSVD) ? LANE_HALF : l;
    endfunction

    function automatic logic [DATA_W-1:0] ifmode_val(input lane_e l, input res_e r);
        case (eff_lane(l))
            LANE_2W: return (r == RES_16 || r == RES_20) ? 8'h4B : 8'h2B;
            LANE_1W: return 8'h6C;
            default: return 8'h8D;
        endcase
    endfunction

    // bit0 source, bit1 divide, bit2 toggle
    function automatic logic [DATA_W-1:0] fclk_val(input lane_e l, input logic cplx);
        logic src, div, tog;
        src = 1'b0; div = 1'b0; tog = 1'b0;
        if (cplx) begin
            if (eff_lane(l) == LANE_HALF) tog = 1'b1;
            else                          src = 1'b1;
        end else if (eff_lane(l) == LANE_2W) begin
            div = 1'b1;
        end
        return {5'b0, tog, div, src};
    endfunction

    function automatic logic [PAT_W-1:0] pattern_val(input lane_e l, input res_e r,
                                                     input logic cplx);
        if (cplx) return 20'hFFFFF;
        case (eff_lane(l))
            LANE_2W: begin
                case (r)
                    RES_16:  return 20'hFF000;
                    RES_18:  return 20'hFF800;
                    default: return 20'hFFC00;
                endcase
            end
            LANE_1W: return 20'hFE000;
            default: return 20'hFFC00;
        endcase
    endfunction

    // {iq_order, q_delay}
    function automatic logic [1:0] iq_bits(input lane_e l, input logic cplx);
        if (!cplx) return 2'b00;
        case (eff_lane(l))
            LANE_2W: return 2'b10;
            LANE_1W: return 2'b01;
            default: return 2'b11;
        endcase
    endfunction

endpackage

// File: rtl/adcseq_step_table.sv
module adcseq_step_table
    import adcseq_pkg::*;
(
    input  seq_cfg_t          cfg,
    input  logic [STEP_W-1:0] idx,
    output step_t             step
);

    logic [DATA_W-1:0] nco_b [NCO_BYTES];
    logic [PAT_W-1:0]  pat;
    logic [1:0]        iq;
    logic [2:0]        nsel;

    for (genvar g = 0; g < NCO_BYTES; g++) begin : g_nco_bytes
        assign nco_b[g] = cfg.nco[8*g +: 8];
    end

    assign pat  = pattern_val(cfg.lane, cfg.res, cfg.cplx);
    assign iq   = iq_bits(cfg.lane, cfg.cplx);
    assign nsel = 3'(idx - STEP_W'(NCO_FIRST));

    always_comb begin
        step      = '0;
        step.used = 1'b1;
        case (idx)
            5'd0: begin step.addr = A_IFMODE;  step.data = ifmode_val(cfg.lane, cfg.res); end
            5'd1: begin step.addr = A_FUSE;    step.data = 8'h01; end
            5'd2: begin step.is_wait = 1'b1; end
            5'd3: begin step.addr = A_FUSE;    step.data = 8'h00; end
            5'd4: begin step.addr = A_FCLK;    step.data = fclk_val(cfg.lane, cfg.cplx); end
            5'd5: begin step.addr = A_PAT_HI;  step.data = {4'h0, pat[19:16]}; end
            5'd6: begin step.addr = A_PAT_MID; step.data = pat[15:8]; end
            5'd7: begin step.addr = A_PAT_LO;  step.data = pat[7:0]; end
            5'd8: begin step.addr = A_IQORD;   step.data = {7'b0, iq[1]}; end
            5'd9: begin step.addr = A_QDEL;    step.data = {7'b0, iq[0]}; end
            5'd10: begin
                step.used = cfg.scr_on | cfg.cplx;
                step.addr = A_DPEN;
                step.data = {6'b0, cfg.cplx, cfg.scr_on};
            end
            5'd19: begin step.addr = A_GAIN; step.data = {cfg.gain, 1'b1}; end
            5'd20: begin step.addr = A_GAIN; step.data = {cfg.gain, 1'b0}; end
            default: begin
                if (idx >= STEP_W'(NCO_FIRST) && idx < STEP_W'(NCO_FIRST + NCO_BYTES)) begin
                    step.used = cfg.cplx;
                    step.addr = nsel[2] ? (A_NCO_HI + {6'b0, nsel[1:0]})
                                        : (A_NCO_LO + {6'b0, nsel[1:0]});
                    step.data = nco_b[nsel];
                end else begin
                    step.used = 1'b0;
                end
            end
        endcase
    end

endmodule

// File: rtl/adcseq_wait_timer.sv
module adcseq_wait_timer #(
    parameter int unsigned WAIT_CYC = 100_000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);

    localparam int CNT_W = $clog2(WAIT_CYC + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (load)         cnt <= CNT_W'(WAIT_CYC);
        else if (cnt != '0)    cnt <= cnt - CNT_W'(1);
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
    import adcseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  seq_cfg_t          cfg_in,
    input  logic              err_in,
    input  step_t             step,
    input  logic              tmr_expired,
    input  logic              wr_ready,
    output seq_cfg_t          cfg_q,
    output logic [STEP_W-1:0] idx,
    output logic              tmr_load,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              done,
    output logic              cfg_err
);

    seq_state_e state;
    logic       fire;
    logic       last;

    assign wr_valid = (state == ST_ISSUE) && step.used && !step.is_wait;
    assign wr_addr  = step.addr;
    assign wr_data  = step.data;
    assign fire     = wr_valid && wr_ready;
    assign tmr_load = (state == ST_ISSUE) && step.used && step.is_wait;
    assign last     = (idx == STEP_W'(NSTEPS - 1));
    assign busy     = (state != ST_DONE);
    assign done     = (state == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_LAUNCH;
            idx     <= '0;
            cfg_q   <= '0;
            cfg_err <= 1'b0;
        end else begin
            case (state)
                ST_LAUNCH: begin
                    cfg_q   <= cfg_in;
                    cfg_err <= err_in;
                    idx     <= '0;
                    state   <= ST_ISSUE;
                end
                ST_ISSUE: begin
                    if (tmr_load) begin
                        state <= ST_WAIT;
                    end else if (!step.used || fire) begin
                        if (last) state <= ST_DONE;
                        else      idx   <= idx + STEP_W'(1);
                    end
                end
                ST_WAIT: begin
                    if (tmr_expired) begin
                        state <= ST_ISSUE;
                        idx   <= idx + STEP_W'(1);
                    end
                end
                default: begin
                    if (start) begin
                        cfg_q   <= cfg_in;
                        cfg_err <= err_in;
                        idx     <= '0;
                        state   <= ST_ISSUE;
                    end
                end
            endcase
        end
    end

    // R2: the fuse clear write is only accepted once the timer has run out
    a_r2_fuse_waited: assert property (@(posedge clk) disable iff (rst)
        (fire && wr_addr == A_FUSE && wr_data == 8'h00) |-> tmr_expired);

    // R11: back-pressure holds the offered write
    a_r11_hold_write: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R12: captured configuration is frozen while the sequence runs
    a_r12_cfg_locked: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ISSUE || state == ST_WAIT) |=> $stable(cfg_q));

    // R12: done stays until a start pulse
    a_r12_done_sticky: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    // R8: error flag only changes at a launch
    a_r8_err_locked: assert property (@(posedge clk) disable iff (rst)
        (busy && state != ST_LAUNCH) |=> $stable(cfg_err));

endmodule

// File: rtl/adc_init_sequencer.sv
module adc_init_sequencer
    import adcseq_pkg::*;
#(
    parameter int unsigned CLK_HZ = 100_000_000,
    parameter int unsigned GAIN_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        lane_mode,
    input  logic [1:0]        out_res,
    input  logic              cplx_dec_en,
    input  logic              scramble_req,
    input  logic [63:0]       nco_freq,
    input  logic [GAIN_W-1:0] ddc_gain,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [7:0]        wr_addr,
    output logic [7:0]        wr_data,
    output logic              busy,
    output logic              done,
    output logic              cfg_err
);

    localparam int unsigned WAIT_RAW = CLK_HZ / 1000;
    localparam int unsigned WAIT_CYC = (WAIT_RAW == 0) ? 1 : WAIT_RAW;

    seq_cfg_t          cfg_in, cfg_q;
    logic              err_in;
    step_t             step;
    logic [STEP_W-1:0] idx;
    logic              tmr_load, tmr_expired;
    lane_e             lane_in;

    assign lane_in = lane_e'(lane_mode);

    always_comb begin
        cfg_in        = '0;
        cfg_in.lane   = lane_in;
        cfg_in.res    = res_e'(out_res);
        cfg_in.cplx   = cplx_dec_en;
        cfg_in.scr_on = scramble_req && (lane_in == LANE_2W);
        cfg_in.nco    = nco_freq;
        cfg_in.gain   = GAIN_FW'(ddc_gain);
    end

    assign err_in = (scramble_req && lane_in != LANE_2W) || (lane_in == LANE_RSVD);

    adcseq_step_table u_table (
        .cfg  (cfg_q),
        .idx  (idx),
        .step (step)
    );

    adcseq_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .expired (tmr_expired)
    );

    adcseq_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .cfg_in      (cfg_in),
        .err_in      (err_in),
        .step        (step),
        .tmr_expired (tmr_expired),
        .wr_ready    (wr_ready),
        .cfg_q       (cfg_q),
        .idx         (idx),
        .tmr_load    (tmr_load),
        .wr_valid    (wr_valid),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .busy        (busy),
        .done        (done),
        .cfg_err     (cfg_err)
    );

    // R1: nothing is offered or finished during reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!done && busy));

endmodule

// File: tb/adc_init_sequencer_tb.sv
module adc_init_sequencer_tb;

    localparam int unsigned CLK_HZ   = 100_000;
    localparam int          WAIT_CYC = CLK_HZ / 1000;
    localparam int          GAIN_W   = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b0;
    logic              start = 1'b0;
    logic [1:0]        lane_mode = '0;
    logic [1:0]        out_res = '0;
    logic              cplx_dec_en = 1'b0;
    logic              scramble_req = 1'b0;
    logic [63:0]       nco_freq = '0;
    logic [GAIN_W-1:0] ddc_gain = '0;
    logic              wr_valid;
    logic              wr_ready = 1'b0;
    logic [7:0]        wr_addr;
    logic [7:0]        wr_data;
    logic              busy, done, cfg_err;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    logic [7:0] ea [0:31];
    logic [7:0] ed [0:31];
    int         en;
    logic       exp_err;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    adc_init_sequencer #(.CLK_HZ(CLK_HZ), .GAIN_W(GAIN_W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .lane_mode(lane_mode), .out_res(out_res),
        .cplx_dec_en(cplx_dec_en), .scramble_req(scramble_req), .nco_freq(nco_freq),
        .ddc_gain(ddc_gain), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .done(done), .cfg_err(cfg_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h07: return "R3";
            8'h13: return "R2";
            8'h19: return "R4";
            8'h20, 8'h21, 8'h22: return "R5";
            8'h27, 8'h2E: return "R6";
            8'h24: return "R7";
            8'h26: return "R10";
            default: return "R9";
        endcase
    endfunction

    task automatic push(input logic [7:0] a, input logic [7:0] d);
        ea[en] = a; ed[en] = d; en++;
    endtask

    task automatic build_exp(input logic [1:0] ln, input logic [1:0] rs, input bit cx,
                             input bit sc, input logic [63:0] nco, input logic [GAIN_W-1:0] g);
        int         l;
        logic [19:0] pat;
        logic [7:0]  ifm, fck;
        bit          ord, dly, scr_ok;
        en  = 0;
        l   = (ln == 2'd3) ? 2 : int'(ln);
        scr_ok  = sc && (ln == 2'd0);
        exp_err = (sc && ln != 2'd0) || (ln == 2'd3);
        ifm = (l == 0) ? ((rs == 2'd1 || rs == 2'd3) ? 8'h4B : 8'h2B) : (l == 1 ? 8'h6C : 8'h8D);
        if (cx) fck = (l == 2) ? 8'h04 : 8'h01;
        else    fck = (l == 0) ? 8'h02 : 8'h00;
        if (cx)          pat = 20'hFFFFF;
        else if (l == 0) pat = (rs == 2'd1) ? 20'hFF000 : (rs == 2'd2) ? 20'hFF800 : 20'hFFC00;
        else if (l == 1) pat = 20'hFE000;
        else             pat = 20'hFFC00;
        ord = cx && (l != 1);
        dly = cx && (l != 0);
        push(8'h07, ifm);
        push(8'h13, 8'h01);
        push(8'h13, 8'h00);
        push(8'h19, fck);
        push(8'h20, {4'h0, pat[19:16]});
        push(8'h21, pat[15:8]);
        push(8'h22, pat[7:0]);
        push(8'h27, {7'b0, ord});
        push(8'h2E, {7'b0, dly});
        if (scr_ok || cx) push(8'h24, {6'b0, cx, scr_ok});
        if (cx) begin
            for (int k = 0; k < 4; k++) push(8'h2A + 8'(k), nco[8*k +: 8]);
            for (int k = 0; k < 4; k++) push(8'h31 + 8'(k), nco[32 + 8*k +: 8]);
        end
        push(8'h26, {3'b000, g, 1'b1});
        push(8'h26, {3'b000, g, 1'b0});
    endtask

    task automatic run_seq(input bit via_reset, input logic [1:0] ln, input logic [1:0] rs,
                           input bit cx, input bit sc, input logic [63:0] nco,
                           input logic [GAIN_W-1:0] g, input bit poke);
        int         n = 0;
        int         t_fuse = -1;
        bit         gap_done = 0;
        bit         stall = 0;
        bit         poked = 0;
        bit         finished = 0;
        logic [7:0] pa = '0, pd = '0;
        lane_mode = ln; out_res = rs; cplx_dec_en = cx; scramble_req = sc;
        nco_freq = nco; ddc_gain = g;
        build_exp(ln, rs, cx, sc, nco, g);
        if (via_reset) begin
            @(negedge clk); rst = 1'b1;
            repeat (2) @(negedge clk);
            check(!wr_valid, "R1", "valid in reset", 64'(wr_valid), 0);
            check(!done && busy, "R1", "done/busy in reset", {62'b0, done, busy}, 64'h1);
            rst = 1'b0;
            @(negedge clk);
        end else begin
            @(negedge clk); start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        // inputs are captured; change them to prove they no longer matter (R12)
        lane_mode = 2'($urandom); out_res = 2'($urandom); cplx_dec_en = 1'($urandom);
        scramble_req = 1'($urandom); nco_freq = {$urandom, $urandom}; ddc_gain = GAIN_W'($urandom);
        for (int guard = 0; guard < 4000; guard++) begin
            if (guard != 0) @(negedge clk);
            if (stall) begin
                check(wr_valid && wr_addr == pa && wr_data == pd, "R11", "held write",
                      {47'b0, wr_valid, wr_addr, wr_data}, {47'b0, 1'b1, pa, pd});
            end
            if (poke && n == 4 && !poked) begin
                start = 1'b1; poked = 1;
            end else begin
                start = 1'b0;
            end
            if (done) begin finished = 1; break; end
            if (wr_valid) begin
                if (wr_addr == 8'h13 && wr_data == 8'h00 && !gap_done && t_fuse >= 0) begin
                    gap_done = 1;
                    check(cyc - t_fuse >= WAIT_CYC, "R2", "fuse wait cycles",
                          64'(cyc - t_fuse), 64'(WAIT_CYC));
                end
                if (($urandom % 3) != 0) begin
                    wr_ready = 1'b1; stall = 0;
                    if (n < en) begin
                        check(wr_addr == ea[n] && wr_data == ed[n], tag_of(ea[n]),
                              $sformatf("write %0d addr/data", n),
                              {48'b0, wr_addr, wr_data}, {48'b0, ea[n], ed[n]});
                    end else begin
                        check(0, "R2", "extra write", {48'b0, wr_addr, wr_data}, 0);
                    end
                    if (wr_addr == 8'h13 && wr_data == 8'h01) t_fuse = cyc;
                    n++;
                end else begin
                    wr_ready = 1'b0; stall = 1; pa = wr_addr; pd = wr_data;
                end
            end else begin
                wr_ready = 1'b0; stall = 0;
            end
        end
        wr_ready = 1'b0; start = 1'b0;
        check(finished, "R12", "sequence finished", 64'(finished), 1);
        check(n == en, "R2", "write count", 64'(n), 64'(en));
        check(gap_done, "R2", "fuse clear seen", 64'(gap_done), 1);
        check(cfg_err == exp_err, "R8", "error flag", 64'(cfg_err), 64'(exp_err));
        check(done && !busy, "R12", "done/busy at end", {62'b0, done, busy}, 64'h2);
        repeat (5) @(negedge clk);
        check(done && !wr_valid, "R12", "done holds, no writes", {62'b0, done, wr_valid}, 64'h2);
        check(cfg_err == exp_err, "R8", "error flag held", 64'(cfg_err), 64'(exp_err));
    endtask

    initial begin
        #2_000_000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: launch from reset, 2-wire 14-bit with scrambler granted
        run_seq(1, 2'd0, 2'd0, 0, 1, 64'h0, 4'h3, 0);
        // R3 R4 R5 R6: every lane x resolution, real path, scrambler requested (R7, R8)
        for (int l = 0; l < 4; l++)
            for (int r = 0; r < 4; r++)
                run_seq(0, 2'(l), 2'(r), 0, 1, 64'h0, 4'(l + r), 0);
        // R9 R10: complex decimation per lane
        for (int l = 0; l < 4; l++)
            run_seq(0, 2'(l), 2'(l), 1, 0, 64'h0123_4567_89AB_CDEF, 4'hA + 4'(l), 0);
        // plain 2-wire with nothing optional
        run_seq(0, 2'd0, 2'd3, 0, 0, 64'hFFFF, 4'hF, 0);
        // R12: start pulse injected mid-sequence
        run_seq(0, 2'd1, 2'd2, 1, 1, 64'hDEAD_BEEF_0000_1111, 4'h5, 1);
        // reset in the middle of nothing, then relaunch
        run_seq(1, 2'd2, 2'd1, 1, 0, 64'h55AA_55AA_1234_5678, 4'h9, 0);
        for (int i = 0; i < 15; i++)
            run_seq(0, 2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                    {$urandom, $urandom}, 4'($urandom), 1'($urandom));
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule